// File: doc/BRIEF.md
# Modulo-Scheduled Configuration Sequencer

This block drives a 4x4 grid of processing elements through one software-pipelined loop. Each clock cycle it hands every element one configuration word, fetched from one of three configuration memories: a setup sequence that also loads the loop's incoming live values into registers, a steady-state body of II words that is replayed a programmed number of times, and a drain sequence that also writes the loop's results back out. When the drain has finished, it raises a single-cycle completion pulse.

The body's pass count is the loop trip count minus two. For example, a 32-iteration loop with II = 7 replays the body 30 times, which is 210 body cycles. While the body runs, the block exports the current slot within the interval, from 0 to II-1, so that rotating-register indexing can follow it. Any element can end the body early by raising its loop-exit line. The configuration memories are read combinationally and are loaded by some other agent.

Top module: `modulo_cfg_sequencer`

## Requirements
- R1: After a start, the phases run in the fixed order setup, body, drain, completion. At most one of phasePro, phaseKer, phaseEpi and done is high in any cycle.
- R2: The setup phase lasts proLen cycles. In setup cycle k, proRdAddr is k and peWords equals proRdData.
- R3: The body phase lasts initInterval × kernelPasses cycles. In body cycle c, kerRdAddr is c mod initInterval and peWords equals kerRdData.
- R4: The drain phase lasts epiLen cycles. In drain cycle k, epiRdAddr is k and peWords equals epiRdData.
- R5: done is high for exactly one cycle, in the cycle after the last drain word. If every phase is empty, done is high in the cycle after the start.
- R6: An empty setup or drain is skipped with no idle cycle. If kernelPasses or initInterval is zero, the body is skipped.
- R7: If any bit of loopExit is high in a body cycle, that cycle's word is still issued and the drain (or done) follows in the next cycle.
- R8: A start that arrives during any phase or during the done cycle has no effect on the running sequence.
- R9: When idle, and during reset, every element receives NOP_WORD (default 32'h7000_0000, the no-operation opcode 7 in bits 31:28), all phase flags are low and modTime is 0.
- R10: During the body, modTime equals the slot index c mod initInterval. Outside the body it is 0.
- R11: The lengths, interval and pass count are captured at the start. Changing these inputs later has no effect on the run.
- R12: The first word of a run is issued in the cycle that follows the clock edge at which start was sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Run request, sampled while idle |
| proLen | input | 5 | Setup length in cycles (0..16) |
| initInterval | input | 5 | Initiation interval II (0..16) |
| kernelPasses | input | 16 | Number of body passes (trip count minus 2) |
| epiLen | input | 5 | Drain length in cycles (0..16) |
| loopExit | input | 16 | Per-element early loop-exit request |
| proRdAddr | output | 4 | Setup memory read address |
| proRdData | input | 512 | Setup words for all 16 elements |
| kerRdAddr | output | 4 | Body memory read address (slot) |
| kerRdData | input | 512 | Body words for all 16 elements |
| epiRdAddr | output | 4 | Drain memory read address |
| epiRdData | input | 512 | Drain words for all 16 elements |
| peWords | output | 512 | Issued words, element p in bits p*32 +: 32 |
| phasePro | output | 1 | Setup phase active |
| phaseKer | output | 1 | Body phase active |
| phaseEpi | output | 1 | Drain phase active |
| modTime | output | 4 | Slot within the interval during the body |
| done | output | 1 | One-cycle completion pulse |

## Verification
Each memory returns a word tagged with its phase, element and address, so a word taken from the wrong memory, element or slot is caught. The run shapes are chosen to tell the cases apart:
- A plain three-phase run and runs with empty setup, empty drain, zero passes, zero interval, or all phases empty, which separate the skip paths from one another.
- II = 1, II = 7 with 30 passes, and the 16-deep limits, which expose wrap errors in the slot counter.
- An early exit in the middle of a pass, which shows whether the exit cycle's word is kept.
- Start pulses during setup and during the done cycle, together with configuration inputs changed after each start, which show whether a busy start or a late input change leaks into the run.

// File: rtl/modseq_pkg.sv
package modseq_pkg;
  typedef enum logic [2:0] {S_IDLE, S_PRO, S_KER, S_EPI, S_FIN} seqState_t;

  typedef struct packed {
    logic       load;     // capture configuration, clear body counters
    logic       stepClr;  // clear setup/drain step counter
    logic       stepInc;  // advance setup/drain step counter
    logic       kerInc;   // advance body slot and pass counters
    seqState_t  phase;    // current phase, selects the issued words
  } seqStrobe_t;
endpackage

// File: rtl/modseq_ctrl.sv
module modseq_ctrl
  import modseq_pkg::*;
#(
  parameter int NUM_PE = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [NUM_PE-1:0] loopExit,
  input  logic              proOn,
  input  logic              kerOn,
  input  logic              epiOn,
  input  logic              proLast,
  input  logic              kerLast,
  input  logic              epiLast,
  output seqStrobe_t        strb,
  output logic              phasePro,
  output logic              phaseKer,
  output logic              phaseEpi,
  output logic              done
);
  seqState_t state, nxt;
  logic anyExit;

  assign anyExit = |loopExit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= S_IDLE;
    else       state <= nxt;
  end

  always_comb begin
    nxt        = state;
    strb       = '0;
    strb.phase = state;
    case (state)
      S_IDLE: if (start) begin
        strb.load    = 1'b1;
        strb.stepClr = 1'b1;
        nxt = proOn ? S_PRO : kerOn ? S_KER : epiOn ? S_EPI : S_FIN;
      end
      S_PRO: begin
        strb.stepInc = 1'b1;
        if (proLast) begin
          strb.stepClr = 1'b1;
          nxt = kerOn ? S_KER : epiOn ? S_EPI : S_FIN;
        end
      end
      S_KER: begin
        strb.kerInc = 1'b1;
        if (kerLast || anyExit) nxt = epiOn ? S_EPI : S_FIN;
      end
      S_EPI: begin
        strb.stepInc = 1'b1;
        if (epiLast) nxt = S_FIN;
      end
      default: nxt = S_IDLE;
    endcase
  end

  assign phasePro = (state == S_PRO);
  assign phaseKer = (state == S_KER);
  assign phaseEpi = (state == S_EPI);
  assign done     = (state == S_FIN);
endmodule

// File: rtl/modseq_dp.sv
module modseq_dp
  import modseq_pkg::*;
#(
  parameter int NUM_PE   = 16,
  parameter int WORD_W   = 32,
  parameter int LEN_W    = 5,
  parameter int SA_W     = 4,
  parameter int II_W     = 5,
  parameter int KA_W     = 4,
  parameter int PASS_W   = 16,
  parameter logic [WORD_W-1:0] NOP_WORD = 32'h7000_0000
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  seqStrobe_t               strb,
  input  logic [LEN_W-1:0]         proLenIn,
  input  logic [II_W-1:0]          iiIn,
  input  logic [PASS_W-1:0]        passIn,
  input  logic [LEN_W-1:0]         epiLenIn,
  output logic [SA_W-1:0]          proRdAddr,
  input  logic [NUM_PE*WORD_W-1:0] proRdData,
  output logic [KA_W-1:0]          kerRdAddr,
  input  logic [NUM_PE*WORD_W-1:0] kerRdData,
  output logic [SA_W-1:0]          epiRdAddr,
  input  logic [NUM_PE*WORD_W-1:0] epiRdData,
  output logic [NUM_PE*WORD_W-1:0] peWords,
  output logic [KA_W-1:0]          modTime,
  output logic                     proOn,
  output logic                     kerOn,
  output logic                     epiOn,
  output logic                     proLast,
  output logic                     kerLast,
  output logic                     epiLast
);
  logic [LEN_W-1:0]  proLenQ, epiLenQ, stepQ, proSel, epiSel;
  logic [II_W-1:0]   iiQ, slotQ, iiSel;
  logic [PASS_W-1:0] passLimQ, passQ, passSel;
  logic              slotWrap;

  // While loading, the skip decision looks at the live inputs.
  assign proSel  = strb.load ? proLenIn : proLenQ;
  assign epiSel  = strb.load ? epiLenIn : epiLenQ;
  assign iiSel   = strb.load ? iiIn     : iiQ;
  assign passSel = strb.load ? passIn   : passLimQ;

  assign proOn = (proSel != '0);
  assign epiOn = (epiSel != '0);
  assign kerOn = (iiSel != '0) && (passSel != '0);

  assign slotWrap = ((slotQ + II_W'(1)) == iiQ);
  assign proLast  = ((stepQ + LEN_W'(1)) == proLenQ);
  assign epiLast  = ((stepQ + LEN_W'(1)) == epiLenQ);
  assign kerLast  = slotWrap && ((passQ + PASS_W'(1)) == passLimQ);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      proLenQ  <= '0;
      epiLenQ  <= '0;
      iiQ      <= '0;
      passLimQ <= '0;
      slotQ    <= '0;
      passQ    <= '0;
      stepQ    <= '0;
    end else begin
      if (strb.load) begin
        proLenQ  <= proLenIn;
        epiLenQ  <= epiLenIn;
        iiQ      <= iiIn;
        passLimQ <= passIn;
        slotQ    <= '0;
        passQ    <= '0;
      end else if (strb.kerInc) begin
        if (slotWrap) begin
          slotQ <= '0;
          passQ <= passQ + PASS_W'(1);
        end else begin
          slotQ <= slotQ + II_W'(1);
        end
      end
      if (strb.stepClr)      stepQ <= '0;
      else if (strb.stepInc) stepQ <= stepQ + LEN_W'(1);
    end
  end

  assign proRdAddr = stepQ[SA_W-1:0];
  assign epiRdAddr = stepQ[SA_W-1:0];
  assign kerRdAddr = slotQ[KA_W-1:0];
  assign modTime   = (strb.phase == S_KER) ? slotQ[KA_W-1:0] : '0;

  for (genvar p = 0; p < NUM_PE; p++) begin : g_pe
    always_comb begin
      case (strb.phase)
        S_PRO:   peWords[p*WORD_W +: WORD_W] = proRdData[p*WORD_W +: WORD_W];
        S_KER:   peWords[p*WORD_W +: WORD_W] = kerRdData[p*WORD_W +: WORD_W];
        S_EPI:   peWords[p*WORD_W +: WORD_W] = epiRdData[p*WORD_W +: WORD_W];
        default: peWords[p*WORD_W +: WORD_W] = NOP_WORD;
      endcase
    end
  end
endmodule

// File: rtl/modulo_cfg_sequencer.sv
module modulo_cfg_sequencer
  import modseq_pkg::*;
#(
  parameter int GRID_ROWS = 4,
  parameter int GRID_COLS = 4,
  parameter int WORD_W    = 32,
  parameter int SEQ_DEPTH = 16,
  parameter int KER_DEPTH = 16,
  parameter int PASS_W    = 16,
  parameter logic [WORD_W-1:0] NOP_WORD = 32'h7000_0000,
  localparam int NUM_PE = GRID_ROWS * GRID_COLS,
  localparam int LEN_W  = $clog2(SEQ_DEPTH + 1),
  localparam int SA_W   = $clog2(SEQ_DEPTH),
  localparam int II_W   = $clog2(KER_DEPTH + 1),
  localparam int KA_W   = $clog2(KER_DEPTH)
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     start,
  input  logic [LEN_W-1:0]         proLen,
  input  logic [II_W-1:0]          initInterval,
  input  logic [PASS_W-1:0]        kernelPasses,
  input  logic [LEN_W-1:0]         epiLen,
  input  logic [NUM_PE-1:0]        loopExit,
  output logic [SA_W-1:0]          proRdAddr,
  input  logic [NUM_PE*WORD_W-1:0] proRdData,
  output logic [KA_W-1:0]          kerRdAddr,
  input  logic [NUM_PE*WORD_W-1:0] kerRdData,
  output logic [SA_W-1:0]          epiRdAddr,
  input  logic [NUM_PE*WORD_W-1:0] epiRdData,
  output logic [NUM_PE*WORD_W-1:0] peWords,
  output logic                     phasePro,
  output logic                     phaseKer,
  output logic                     phaseEpi,
  output logic [KA_W-1:0]          modTime,
  output logic                     done
);
  seqStrobe_t strb;
  logic proOn, kerOn, epiOn, proLast, kerLast, epiLast;

  modseq_ctrl #(.NUM_PE(NUM_PE)) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .loopExit(loopExit),
    .proOn(proOn), .kerOn(kerOn), .epiOn(epiOn),
    .proLast(proLast), .kerLast(kerLast), .epiLast(epiLast),
    .strb(strb), .phasePro(phasePro), .phaseKer(phaseKer),
    .phaseEpi(phaseEpi), .done(done)
  );

  modseq_dp #(
    .NUM_PE(NUM_PE), .WORD_W(WORD_W), .LEN_W(LEN_W), .SA_W(SA_W),
    .II_W(II_W), .KA_W(KA_W), .PASS_W(PASS_W), .NOP_WORD(NOP_WORD)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb),
    .proLenIn(proLen), .iiIn(initInterval), .passIn(kernelPasses), .epiLenIn(epiLen),
    .proRdAddr(proRdAddr), .proRdData(proRdData),
    .kerRdAddr(kerRdAddr), .kerRdData(kerRdData),
    .epiRdAddr(epiRdAddr), .epiRdData(epiRdData),
    .peWords(peWords), .modTime(modTime),
    .proOn(proOn), .kerOn(kerOn), .epiOn(epiOn),
    .proLast(proLast), .kerLast(kerLast), .epiLast(epiLast)
  );
endmodule

// File: rtl/modseq_checker.sv
module modseq_checker #(
  parameter int NUM_PE = 16,
  parameter int WORD_W = 32,
  parameter int SA_W   = 4,
  parameter int KA_W   = 4,
  parameter logic [WORD_W-1:0] NOP_WORD = 32'h7000_0000
) (
  input logic                     clk,
  input logic                     rstN,
  input logic [NUM_PE-1:0]        loopExit,
  input logic [SA_W-1:0]          proRdAddr,
  input logic [NUM_PE*WORD_W-1:0] peWords,
  input logic                     phasePro,
  input logic                     phaseKer,
  input logic                     phaseEpi,
  input logic [KA_W-1:0]          modTime,
  input logic                     done
);
  a_r1_phase_onehot: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({phasePro, phaseKer, phaseEpi, done}));

  a_r1_pro_moves_forward: assert property (@(posedge clk) disable iff (!rstN)
    phasePro |=> (phasePro || phaseKer || phaseEpi || done));

  a_r2_pro_addr_steps: assert property (@(posedge clk) disable iff (!rstN)
    (phasePro && $past(phasePro)) |-> (proRdAddr == SA_W'($past(proRdAddr) + 1'b1)));

  a_r4_epi_then_done: assert property (@(posedge clk) disable iff (!rstN)
    phaseEpi |=> (phaseEpi || done));

  a_r5_done_single: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  a_r7_exit_leaves_kernel: assert property (@(posedge clk) disable iff (!rstN)
    (phaseKer && (|loopExit)) |=> !phaseKer);

  a_r9_idle_nop: assert property (@(posedge clk) disable iff (!rstN)
    !(phasePro || phaseKer || phaseEpi) |-> (peWords == {NUM_PE{NOP_WORD}} && modTime == '0));

  a_r10_slot_advances: assert property (@(posedge clk) disable iff (!rstN)
    (phaseKer && $past(phaseKer)) |-> (modTime == KA_W'($past(modTime) + 1'b1) || modTime == '0));
endmodule

bind modulo_cfg_sequencer modseq_checker #(
  .NUM_PE(NUM_PE), .WORD_W(WORD_W), .SA_W(SA_W), .KA_W(KA_W), .NOP_WORD(NOP_WORD)
) u_chk (
  .clk(clk), .rstN(rstN), .loopExit(loopExit), .proRdAddr(proRdAddr),
  .peWords(peWords), .phasePro(phasePro), .phaseKer(phaseKer),
  .phaseEpi(phaseEpi), .modTime(modTime), .done(done)
);

// File: tb/modulo_cfg_sequencer_bench.sv
module modulo_cfg_sequencer_bench;
  localparam int NPE = 16;
  localparam int WW  = 32;
  localparam logic [WW-1:0] NOP = 32'h7000_0000;

  typedef struct packed {
    int pro; int ii; int cnt; int epi; int exitAt; int poke;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VECS [NV] = '{
    '{3, 2, 3, 2, -1, 11},   // R1 plain run; R8 start poked in the done cycle (index 11)
    '{0, 3, 2, 1, -1, -1},   // R6 empty setup
    '{2, 4, 0, 2, -1, -1},   // R6 zero passes
    '{1, 1, 4, 0, -1, -1},   // R6 empty drain, II of 1
    '{2, 7, 30, 3, -1, -1},  // R3 trip 32 loop: 30 passes of 7
    '{2, 3, 5, 2, 4, -1},    // R7 early exit mid-pass
    '{0, 0, 5, 0, -1, -1},   // R5 R6 zero interval, everything empty
    '{4, 2, 2, 1, -1, 2},    // R8 start poked during setup
    '{16, 16, 1, 16, -1, -1} // R10 depth limits
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic [4:0] proLen = '0, initInterval = '0, epiLen = '0;
  logic [15:0] kernelPasses = '0;
  logic [NPE-1:0] loopExit = '0;
  logic [3:0] proRdAddr, kerRdAddr, epiRdAddr, modTime;
  logic [NPE*WW-1:0] proRdData, kerRdData, epiRdData, peWords;
  logic phasePro, phaseKer, phaseEpi, done;
  int total = 0, bad = 0;

  always #5 clk = ~clk;

  always_comb begin
    for (int p = 0; p < NPE; p++) begin
      proRdData[p*WW +: WW] = {8'hA1, 8'(p), 12'h0, proRdAddr};
      kerRdData[p*WW +: WW] = {8'hB2, 8'(p), 12'h0, kerRdAddr};
      epiRdData[p*WW +: WW] = {8'hC3, 8'(p), 12'h0, epiRdAddr};
    end
  end

  modulo_cfg_sequencer u_modulo_cfg_sequencer (
    .clk(clk), .rstN(rstN), .start(start), .proLen(proLen),
    .initInterval(initInterval), .kernelPasses(kernelPasses), .epiLen(epiLen),
    .loopExit(loopExit), .proRdAddr(proRdAddr), .proRdData(proRdData),
    .kerRdAddr(kerRdAddr), .kerRdData(kerRdData), .epiRdAddr(epiRdAddr),
    .epiRdData(epiRdData), .peWords(peWords), .phasePro(phasePro),
    .phaseKer(phaseKer), .phaseEpi(phaseEpi), .modTime(modTime), .done(done)
  );

  function automatic logic [NPE*WW-1:0] expWords(logic [7:0] tag, int a);
    logic [NPE*WW-1:0] v;
    for (int p = 0; p < NPE; p++)
      v[p*WW +: WW] = (tag == 8'h00) ? NOP : {tag, 8'(p), 12'h0, 4'(a)};
    return v;
  endfunction

  task automatic chk(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic runVec(vec_t v);
    int kerLen, len, kc, a, mt;
    logic [3:0] ph;
    logic [7:0] tag;
    string req;
    kerLen = (v.ii == 0 || v.cnt == 0) ? 0 : v.ii * v.cnt;
    if (v.exitAt >= 0 && kerLen > 0) kerLen = v.exitAt + 1;
    len = v.pro + kerLen + v.epi;
    @(negedge clk);
    proLen = 5'(v.pro); initInterval = 5'(v.ii);
    kernelPasses = 16'(v.cnt); epiLen = 5'(v.epi);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    // R11: scramble the configuration after the start
    proLen = 5'd5; initInterval = 5'd9; kernelPasses = 16'd1; epiLen = 5'd7;
    for (int k = 0; k < len + 3; k++) begin
      a = 0; mt = 0; loopExit = '0;
      if (k < v.pro) begin
        ph = 4'b1000; tag = 8'hA1; a = k; req = "R2";         // R12 first word at k=0
      end else if (k < v.pro + kerLen) begin
        kc = k - v.pro; ph = 4'b0100; tag = 8'hB2;
        a = kc % v.ii; mt = a; req = "R3";
        if (kc == v.exitAt) loopExit = 16'h0020;              // R7
      end else if (k < len) begin
        ph = 4'b0010; tag = 8'hC3; a = k - v.pro - kerLen; req = "R4";
      end else if (k == len) begin
        ph = 4'b0001; tag = 8'h00; req = "R5";
      end else begin
        ph = 4'b0000; tag = 8'h00; req = "R9";
      end
      start = (k == v.poke);                                  // R8
      chk({phasePro, phaseKer, phaseEpi, done} == ph, "R1", "phase",
          64'({phasePro, phaseKer, phaseEpi, done}), 64'(ph));
      chk(modTime == 4'(mt), "R10", "modTime", 64'(modTime), 64'(mt));
      chk(peWords == expWords(tag, a), req, "word pe0",
          64'(peWords[WW-1:0]), 64'(expWords(tag, a) >> 0) & 64'hFFFF_FFFF);
      @(negedge clk);
    end
    loopExit = '0; start = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL R1 watchdog actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    // R9: reset state, with a start request held during reset
    start = 1'b1;
    repeat (2) @(negedge clk);
    chk({phasePro, phaseKer, phaseEpi, done} == 4'b0, "R9", "reset phase",
        64'({phasePro, phaseKer, phaseEpi, done}), 64'h0);
    chk(peWords == expWords(8'h00, 0), "R9", "reset words", 64'(peWords[WW-1:0]), 64'(NOP));
    chk(modTime == 4'd0, "R9", "reset modTime", 64'(modTime), 64'h0);
    start = 1'b0;
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    chk(done == 1'b0 && phasePro == 1'b0, "R9", "idle after reset",
        64'({phasePro, done}), 64'h0);
    for (int i = 0; i < NV; i++) runVec(VECS[i]);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule